// File: doc/BRIEF.md
# Shift and Bit-Manipulation Unit

A purely combinational datapath slice that takes one operand word, a shift count taken from a register and a three-bit operation code. It returns one result word and, for the four shift kinds only, a flag-write strobe with negative and zero flag values. The unit supports four shift kinds (shift left, shift right with zero fill, shift right with sign fill, rotate right), one counting operation (count leading zeros) and bit-order reversal.

Each shift kind has its own legal count window. A count outside that window is pulled to the nearest legal value rather than wrapped, so a large register value never produces a surprising small shift. Right shifts allow a count equal to the word width, which clears the word or fills it entirely with the sign. Counting and reversal never request a flag update.

Top module: `shift_bit_unit`

## Requirements
- R1: Opcode 0 shifts left, filling with zeros; counts 0 to 31 are applied as given and any larger count acts as 31.
- R2: Opcode 1 shifts right, filling with zeros; counts 1 to 32 are applied, a count of 32 gives zero, a count of 0 acts as 1 and a count above 32 acts as 32.
- R3: Opcode 2 shifts right, filling with copies of operand bit 31; counts are limited as in R2, and a count of 32 gives every bit equal to operand bit 31.
- R4: Opcode 3 rotates right with bits leaving bit 0 entering at bit 31; counts 1 to 31 are applied, 0 acts as 1 and above 31 acts as 31. Rotating by 3 gives b2 b1 b0 b31 ... b3.
- R5: Opcode 4 returns, zero-extended, the number of zero bits above the highest set operand bit, and 32 for an all-zero operand; the count input is ignored.
- R6: Opcode 5 returns the operand with bit i moved to bit 31-i; the count input is ignored.
- R7: For opcodes 0 to 3 the flag-write strobe is 1, the negative flag equals result bit 31 and the zero flag is 1 exactly when the result is zero.
- R8: For opcodes 4 and 5 the flag-write strobe, negative flag and zero flag are all 0.
- R9: Opcodes 6 and 7 are reserved: the result equals the operand and the flag-write strobe and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select (encoding in R1 to R9) |
| src_val | input | DATA_W (32) | Operand word |
| amt_val | input | AMT_IN_W (8) | Shift count from a register |
| res_val | output | DATA_W (32) | Result word |
| flag_wr | output | 1 | Flag update request, shifts only |
| flag_neg | output | 1 | Negative flag value |
| flag_zero | output | 1 | Zero flag value |

## Verification
The bench builds the unit with its defaults, a 32-bit word and an 8-bit count input. The 8-bit count makes values far above the word width reachable, so the saturation edges at 31, 32 and 255 are driven directly, and the six-stage shifter is exercised through its final stage that moves a full word. Independent reference functions produce the expected result and flags for every vector, including all-zero, single-bit and sign-bit operands.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROR  = 3'd3,
        OP_CLZ  = 3'd4,
        OP_REV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } bitop_e;

    typedef enum logic [1:0] {
        SK_ZERO_FILL = 2'd0,
        SK_SIGN_FILL = 2'd1,
        SK_WRAP      = 2'd2
    } shkind_e;

    typedef struct packed {
        logic wr;
        logic neg;
        logic zero;
    } flagset_t;

    function automatic logic op_is_shift(bitop_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR) || (op == OP_ROR);
    endfunction

    function automatic logic op_right_full(bitop_e op);
        return (op == OP_SHR) || (op == OP_SAR);
    endfunction

endpackage

// File: rtl/amt_clamp.sv
module amt_clamp
    import bitops_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8,
    localparam int STAGE_N = $clog2(DATA_W) + 1
) (
    input  bitop_e              op,
    input  logic [AMT_IN_W-1:0] amt_in,
    output logic [STAGE_N-1:0]  amt_out
);

    logic [31:0] amt_ext;
    logic [31:0] lo_lim;
    logic [31:0] hi_lim;
    logic [31:0] sel;

    always_comb begin
        amt_ext = 32'(amt_in);
        lo_lim  = (op == OP_SHL) ? 32'd0 : 32'd1;
        hi_lim  = op_right_full(op) ? 32'(DATA_W) : 32'(DATA_W - 1);
        if (amt_ext < lo_lim)
            sel = lo_lim;
        else if (amt_ext > hi_lim)
            sel = hi_lim;
        else
            sel = amt_ext;
        amt_out = sel[STAGE_N-1:0];
    end

endmodule

// File: rtl/bit_mirror.sv
module bit_mirror #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout[i] = din[DATA_W-1-i];
    end

endmodule

// File: rtl/right_shifter.sv
module right_shifter
    import bitops_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int STAGE_N = $clog2(DATA_W) + 1
) (
    input  shkind_e             kind,
    input  logic [DATA_W-1:0]   din,
    input  logic [STAGE_N-1:0]  amt,
    output logic [DATA_W-1:0]   dout
);

    logic                            fill;
    logic                            wrap;
    logic [STAGE_N:0][DATA_W-1:0]    stg;

    assign fill   = (kind == SK_SIGN_FILL) ? din[DATA_W-1] : 1'b0;
    assign wrap   = (kind == SK_WRAP);
    assign stg[0] = din;

    for (genvar k = 0; k < STAGE_N; k++) begin : g_stage
        localparam int STEP = 1 << k;
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (i + STEP < DATA_W) begin : g_inner
                assign stg[k+1][i] = amt[k] ? stg[k][i+STEP] : stg[k][i];
            end else if (STEP < DATA_W) begin : g_edge
                assign stg[k+1][i] = amt[k] ? (wrap ? stg[k][(i+STEP) % DATA_W] : fill)
                                            : stg[k][i];
            end else begin : g_full
                assign stg[k+1][i] = amt[k] ? (wrap ? stg[k][i] : fill) : stg[k][i];
            end
        end
    end

    assign dout = stg[STAGE_N];

endmodule

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] din,
    output logic [CNT_W-1:0]  cnt
);

    always_comb begin
        cnt = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (din[i])
                cnt = CNT_W'(DATA_W - 1 - i);
        end
    end

endmodule

// File: rtl/shift_bit_unit.sv
module shift_bit_unit
    import bitops_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8
) (
    input  logic [2:0]          op_code,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [AMT_IN_W-1:0] amt_val,
    output logic [DATA_W-1:0]   res_val,
    output logic                flag_wr,
    output logic                flag_neg,
    output logic                flag_zero
);

    localparam int STAGE_N = $clog2(DATA_W) + 1;
    localparam int CNT_W   = $clog2(DATA_W + 1);

    bitop_e              op;
    shkind_e             kind;
    logic [STAGE_N-1:0]  amt_eff;
    logic [DATA_W-1:0]   src_rev;
    logic [DATA_W-1:0]   sh_in;
    logic [DATA_W-1:0]   sh_out;
    logic [DATA_W-1:0]   sh_out_rev;
    logic [CNT_W-1:0]    lz_cnt;
    flagset_t            flags;

    assign op = bitop_e'(op_code);

    amt_clamp #(.DATA_W(DATA_W), .AMT_IN_W(AMT_IN_W)) u_clamp (
        .op      (op),
        .amt_in  (amt_val),
        .amt_out (amt_eff)
    );

    bit_mirror #(.DATA_W(DATA_W)) u_mirror_in (
        .din  (src_val),
        .dout (src_rev)
    );

    always_comb begin
        unique case (op)
            OP_SAR:  kind = SK_SIGN_FILL;
            OP_ROR:  kind = SK_WRAP;
            default: kind = SK_ZERO_FILL;
        endcase
        sh_in = (op == OP_SHL) ? src_rev : src_val;
    end

    right_shifter #(.DATA_W(DATA_W)) u_shift (
        .kind (kind),
        .din  (sh_in),
        .amt  (amt_eff),
        .dout (sh_out)
    );

    bit_mirror #(.DATA_W(DATA_W)) u_mirror_out (
        .din  (sh_out),
        .dout (sh_out_rev)
    );

    lead_zero_count #(.DATA_W(DATA_W)) u_lzc (
        .din (src_val),
        .cnt (lz_cnt)
    );

    always_comb begin
        unique case (op)
            OP_SHL:                 res_val = sh_out_rev;
            OP_SHR, OP_SAR, OP_ROR: res_val = sh_out;
            OP_CLZ:                 res_val = DATA_W'(lz_cnt);
            OP_REV:                 res_val = src_rev;
            default:                res_val = src_val;
        endcase
    end

    always_comb begin
        flags = '0;
        if (op_is_shift(op)) begin
            flags.wr   = 1'b1;
            flags.neg  = res_val[DATA_W-1];
            flags.zero = (res_val == '0);
        end
    end

    assign flag_wr   = flags.wr;
    assign flag_neg  = flags.neg;
    assign flag_zero = flags.zero;

endmodule

// File: rtl/shift_bit_unit_chk.sv
module shift_bit_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8
) (
    input logic [2:0]          op_code,
    input logic [DATA_W-1:0]   src_val,
    input logic [AMT_IN_W-1:0] amt_val,
    input logic [DATA_W-1:0]   res_val,
    input logic                flag_wr,
    input logic                flag_neg,
    input logic                flag_zero
);

    logic known;
    assign known = !$isunknown({op_code, src_val, amt_val});

    always_comb begin
        if (known) begin
            if (op_code == 3'd4)
                assert_clz_range_R5: assert (res_val <= DATA_W'(DATA_W));
            if (op_code == 3'd5)
                assert_rev_ones_R6: assert ($countones(res_val) == $countones(src_val));
            if (op_code == 3'd3)
                assert_ror_ones_R4: assert ($countones(res_val) == $countones(src_val));
            if (op_code == 3'd4 || op_code == 3'd5)
                assert_no_flags_R8: assert (!flag_wr && !flag_neg && !flag_zero);
            if (op_code == 3'd1 && 32'(amt_val) >= 32'(DATA_W))
                assert_shr_clear_R2: assert (res_val == '0);
            if (op_code == 3'd2)
                assert_sign_keep_R3: assert (res_val[DATA_W-1] == src_val[DATA_W-1]);
            if (op_code == 3'd0 && amt_val != '0)
                assert_shl_lsb_R1: assert (res_val[0] == 1'b0);
            if (flag_wr && flag_zero)
                assert_flag_excl_R7: assert (!flag_neg);
            if (op_code[2:1] == 2'b11)
                assert_reserved_R9: assert (res_val == src_val && !flag_wr);
        end
    end

endmodule

bind shift_bit_unit shift_bit_unit_chk #(.DATA_W(DATA_W), .AMT_IN_W(AMT_IN_W)) u_chk (
    .op_code   (op_code),
    .src_val   (src_val),
    .amt_val   (amt_val),
    .res_val   (res_val),
    .flag_wr   (flag_wr),
    .flag_neg  (flag_neg),
    .flag_zero (flag_zero)
);

// File: tb/shift_bit_unit_test.sv
module shift_bit_unit_test;

    logic        clk = 1'b0;
    logic [2:0]  op_code;
    logic [31:0] src_val;
    logic [7:0]  amt_val;
    logic [31:0] res_val;
    logic        flag_wr, flag_neg, flag_zero;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shift_bit_unit uut (
        .op_code   (op_code),
        .src_val   (src_val),
        .amt_val   (amt_val),
        .res_val   (res_val),
        .flag_wr   (flag_wr),
        .flag_neg  (flag_neg),
        .flag_zero (flag_zero)
    );

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [31:0] model_res(logic [2:0] op, logic [31:0] x, logic [7:0] a);
        int s;
        logic [31:0] r;
        case (op)
            3'd0: begin s = clampi(int'(a), 0, 31); r = x << s; end
            3'd1: begin s = clampi(int'(a), 1, 32); r = (s == 32) ? 32'd0 : (x >> s); end
            3'd2: begin
                s = clampi(int'(a), 1, 32);
                r = (s == 32) ? {32{x[31]}} : 32'($signed(x) >>> s);
            end
            3'd3: begin s = clampi(int'(a), 1, 31); r = (x >> s) | (x << (32 - s)); end
            3'd4: begin
                r = 32'd0;
                for (int i = 31; i >= 0; i--) begin
                    if (x[i]) break;
                    r = r + 32'd1;
                end
            end
            3'd5: for (int i = 0; i < 32; i++) r[i] = x[31-i];
            default: r = x;
        endcase
        return r;
    endfunction

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // drive away from the rising edge, sample after settling
    task automatic apply_and_check(string req, logic [2:0] op, logic [31:0] x, logic [7:0] a);
        logic [31:0] er;
        logic sh;
        @(negedge clk);
        op_code = op; src_val = x; amt_val = a;
        #1;
        er = model_res(op, x, a);
        sh = (op <= 3'd3);
        check(req, "result", res_val, er);
        check(sh ? "R7" : (op >= 3'd6 ? "R9" : "R8"), "flags",
              {29'd0, flag_wr, flag_neg, flag_zero},
              {29'd0, sh, sh & er[31], sh & (er == 32'd0)});
    endtask

    task automatic t_idle;
        apply_and_check("R5", 3'd4, 32'd0, 8'd0);
        check("R5", "zero operand count", res_val, 32'd32);
    endtask

    task automatic t_shl;   // R1
        apply_and_check("R1", 3'd0, 32'hA5A5_0F0F, 8'd0);
        apply_and_check("R1", 3'd0, 32'h8000_0001, 8'd1);
        apply_and_check("R1", 3'd0, 32'h0000_0003, 8'd31);
        apply_and_check("R1", 3'd0, 32'h0000_0003, 8'd40);
        check("R1", "saturated 31", res_val, 32'h8000_0000);
        apply_and_check("R1", 3'd0, 32'hFFFF_FFFF, 8'd255);
    endtask

    task automatic t_shr;   // R2
        apply_and_check("R2", 3'd1, 32'h8000_0000, 8'd0);
        check("R2", "zero count acts as one", res_val, 32'h4000_0000);
        apply_and_check("R2", 3'd1, 32'hF000_000F, 8'd4);
        apply_and_check("R2", 3'd1, 32'hFFFF_FFFF, 8'd31);
        apply_and_check("R2", 3'd1, 32'hFFFF_FFFF, 8'd32);
        check("R2", "full shift clears", res_val, 32'd0);
        apply_and_check("R2", 3'd1, 32'hFFFF_FFFF, 8'd200);
    endtask

    task automatic t_sar;   // R3
        apply_and_check("R3", 3'd2, 32'h8000_0000, 8'd4);
        check("R3", "sign fill", res_val, 32'hF800_0000);
        apply_and_check("R3", 3'd2, 32'h7FFF_FFFF, 8'd4);
        apply_and_check("R3", 3'd2, 32'h9000_0000, 8'd32);
        check("R3", "all sign copies", res_val, 32'hFFFF_FFFF);
        apply_and_check("R3", 3'd2, 32'h1234_5678, 8'd99);
        apply_and_check("R3", 3'd2, 32'hC000_0000, 8'd0);
    endtask

    task automatic t_ror;   // R4
        apply_and_check("R4", 3'd3, 32'h0000_0005, 8'd3);
        check("R4", "rotate by 3", res_val, 32'hA000_0000);
        apply_and_check("R4", 3'd3, 32'h0000_0001, 8'd0);
        check("R4", "zero count acts as one", res_val, 32'h8000_0000);
        apply_and_check("R4", 3'd3, 32'h8000_0000, 8'd31);
        apply_and_check("R4", 3'd3, 32'h8000_0000, 8'd32);
        check("R4", "count above 31 acts as 31", res_val, 32'h0000_0001);
    endtask

    task automatic t_clz;   // R5
        apply_and_check("R5", 3'd4, 32'h0000_0001, 8'd7);
        check("R5", "single low bit", res_val, 32'd31);
        apply_and_check("R5", 3'd4, 32'h8000_0000, 8'd0);
        apply_and_check("R5", 3'd4, 32'h0001_FFFF, 8'd255);
        check("R5", "count ignores amount", res_val, 32'd15);
    endtask

    task automatic t_rev;   // R6
        apply_and_check("R6", 3'd5, 32'h0000_0001, 8'd9);
        check("R6", "bit0 to bit31", res_val, 32'h8000_0000);
        apply_and_check("R6", 3'd5, 32'h1234_5678, 8'd0);
        check("R6", "pattern", res_val, 32'h1E6A_2C48);
    endtask

    task automatic t_flags; // R7, R8
        apply_and_check("R7", 3'd1, 32'h0000_0001, 8'd1);
        check("R7", "zero flag", {31'd0, flag_zero}, 32'd1);
        apply_and_check("R7", 3'd0, 32'h0000_0001, 8'd31);
        check("R7", "negative flag", {31'd0, flag_neg}, 32'd1);
        apply_and_check("R8", 3'd4, 32'd0, 8'd0);
        check("R8", "no write on count", {31'd0, flag_wr}, 32'd0);
        apply_and_check("R8", 3'd5, 32'h0000_0001, 8'd0);
        check("R8", "no write on reverse", {31'd0, flag_wr}, 32'd0);
    endtask

    task automatic t_reserved; // R9
        apply_and_check("R9", 3'd6, 32'hDEAD_BEEF, 8'd5);
        check("R9", "passthrough 6", res_val, 32'hDEAD_BEEF);
        apply_and_check("R9", 3'd7, 32'h0000_0000, 8'd40);
        check("R9", "no write 7", {31'd0, flag_wr}, 32'd0);
    endtask

    initial begin
        op_code = 3'd4; src_val = 32'd0; amt_val = 8'd0;
        t_idle();
        t_shl();
        t_shr();
        t_sar();
        t_ror();
        t_clz();
        t_rev();
        t_flags();
        t_reserved();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule